// File: doc/BRIEF.md
# Output Capture Serializer with Status Latch

This block lets a slow host read two 16-bit result buses and one status event through a few single-bit read lines. It holds a 32-bit capture register. A rising edge on a software-driven load control bit copies both buses into it in one step. Each later rising edge on a separate shift control bit moves the register one place toward its serial output. The host toggles these control bits through register writes, and it reads one bit per shift.

A second path watches one of four status inputs. These inputs are high when idle, and the status path catches any low-going event on the selected one. While an arm bit is high, a low level on the selected input sets a sticky flag. The flag clears only when the arm bit is low and the selected input has gone back high. Static select inputs stand in for board jumpers. They choose the status input, decide which of two host read lines carries the flag, and enable the serial output onto a third read line.

Top module: `capture_serializer`

## Requirements
- R1: Reset clears the capture register and the status flag. After reset all three host read lines are low, even with the serial enable set.
- R2: On a rising edge of the load control, the register captures the first bus into bits 31..16 and the second bus into bits 15..0. The serial line shows register bit 0 (second bus bit 0) one clock later.
- R3: Each rising edge of the shift control moves the register one place toward bit 0, so after k shifts the serial line shows captured bit k. Zeros enter at bit 31, so the line is low after 32 shifts.
- R4: Loading and shifting act only on rising edges. A control bit held high for several clocks causes only one operation.
- R5: If the load and shift controls rise in the same clock, the load takes effect and the shift is dropped.
- R6: When the serial enable is low, host read line 2 is low whatever the register holds.
- R7: A 2-bit select picks the status input (0..3) that the latch watches. The other status inputs have no effect on the flag.
- R8: While the arm bit is high, a low level on the selected status input sets the flag within one clock.
- R9: Once set, the flag stays set until the arm bit is low and the selected status input is high at the same time. Dropping arm while the input is still low does not clear it.
- R10: The flag drives host read line 0 when the route select is 0 and host read line 1 when it is 1. The line that is not routed is held low.
- R11: Changes on the result buses without a load edge do not alter the data being shifted out.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_ctl | input | 1 | Software-toggled load control; rising edge captures the buses |
| shift_ctl | input | 1 | Software-toggled shift control; rising edge shifts one place |
| arm_ctl | input | 1 | Arm bit of the status latch |
| bus_hi | input | 16 | First result bus, captured into bits 31..16 |
| bus_lo | input | 16 | Second result bus, captured into bits 15..0 |
| stat_in | input | 4 | Status inputs, idle high |
| stat_sel | input | 2 | Selects the watched status input |
| route_sel | input | 1 | 0: flag on host_rd[0]; 1: flag on host_rd[1] |
| ser_en | input | 1 | Enables the serial bit onto host_rd[2] |
| host_rd | output | 3 | Host read lines: [0],[1] flag, [2] serial data |

## Verification
The serializer is driven with four capture patterns, and all 32 bits of each are read back one shift at a time:
- a single set bit at each end, which catches a reversed bit order or swapped bus halves;
- a half-ones, half-zeros word, which exposes an off-by-one in the shift count;
- a mixed irregular word, which catches a dropped or repeated bit;
- a complementary half-split word.

After each readout the bench makes one more read, which shows whether the vacated end fills with zeros. Directed sequences cover the remaining cases:
- control levels held high;
- load and shift rising together;
- bus changes without a load;
- an unselected status input going low;
- a clear attempted while the selected input is still low;
- both route settings.

// File: rtl/cs_pkg.sv
package cs_pkg;
    typedef enum logic {
        FLAG_ON_RD0 = 1'b0,
        FLAG_ON_RD1 = 1'b1
    } flag_route_e;

    localparam int RD_SER  = 2;
    localparam int RD_LINES = 3;
endpackage

// File: rtl/cs_edge.sv
module cs_edge #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] lvl,
    output logic [W-1:0] rise
);
    typedef struct packed {
        logic [W-1:0] prev;
    } edge_st_t;

    edge_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.prev = lvl;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    for (genvar i = 0; i < W; i++) begin : g_rise
        assign rise[i] = lvl[i] & ~st_q.prev[i];
    end
endmodule

// File: rtl/cs_shifter.sv
module cs_shifter #(
    parameter int BUS_W = 16,
    localparam int SR_W = 2 * BUS_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             do_load,
    input  logic             do_shift,
    input  logic [BUS_W-1:0] hi,
    input  logic [BUS_W-1:0] lo,
    output logic [SR_W-1:0]  sr
);
    typedef struct packed {
        logic [SR_W-1:0] data;
    } sh_st_t;

    sh_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (do_load)
            st_d.data = {hi, lo};
        else if (do_shift)
            st_d.data = {1'b0, st_q.data[SR_W-1:1]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sr = st_q.data;
endmodule

// File: rtl/cs_status.sv
module cs_status #(
    parameter int N_STAT = 4,
    localparam int SEL_W = (N_STAT > 1) ? $clog2(N_STAT) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              arm,
    input  logic [N_STAT-1:0] stat,
    input  logic [SEL_W-1:0]  sel,
    output logic              flag
);
    typedef struct packed {
        logic hit;
    } lat_st_t;

    lat_st_t st_d, st_q;
    logic    watched;

    always_comb begin
        watched = 1'b1;
        for (int i = 0; i < N_STAT; i++) begin
            if (sel == SEL_W'(i)) watched = stat[i];
        end
    end

    always_comb begin
        st_d = st_q;
        if (arm && !watched)
            st_d.hit = 1'b1;
        else if (!arm && watched)
            st_d.hit = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flag = st_q.hit;
endmodule

// File: rtl/capture_serializer.sv
module capture_serializer
    import cs_pkg::*;
#(
    parameter int BUS_W  = 16,
    parameter int N_STAT = 4,
    localparam int SR_W  = 2 * BUS_W,
    localparam int SEL_W = (N_STAT > 1) ? $clog2(N_STAT) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load_ctl,
    input  logic                shift_ctl,
    input  logic                arm_ctl,
    input  logic [BUS_W-1:0]    bus_hi,
    input  logic [BUS_W-1:0]    bus_lo,
    input  logic [N_STAT-1:0]   stat_in,
    input  logic [SEL_W-1:0]    stat_sel,
    input  logic                route_sel,
    input  logic                ser_en,
    output logic [RD_LINES-1:0] host_rd
);
    logic [1:0]      rise;
    logic [SR_W-1:0] sr_q;
    logic            flag_q;
    flag_route_e     route;

    cs_edge #(.W(2)) u_edge (
        .clk  (clk),
        .rst_n(rst_n),
        .lvl  ({load_ctl, shift_ctl}),
        .rise (rise)
    );

    cs_shifter #(.BUS_W(BUS_W)) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .do_load (rise[1]),
        .do_shift(rise[0]),
        .hi      (bus_hi),
        .lo      (bus_lo),
        .sr      (sr_q)
    );

    cs_status #(.N_STAT(N_STAT)) u_stat (
        .clk  (clk),
        .rst_n(rst_n),
        .arm  (arm_ctl),
        .stat (stat_in),
        .sel  (stat_sel),
        .flag (flag_q)
    );

    always_comb begin
        route           = flag_route_e'(route_sel);
        host_rd         = '0;
        host_rd[0]      = flag_q & (route == FLAG_ON_RD0);
        host_rd[1]      = flag_q & (route == FLAG_ON_RD1);
        host_rd[RD_SER] = ser_en & sr_q[0];
    end
endmodule

// File: rtl/cs_checker.sv
module cs_checker #(
    parameter int BUS_W  = 16,
    parameter int N_STAT = 4,
    localparam int SR_W  = 2 * BUS_W,
    localparam int SEL_W = (N_STAT > 1) ? $clog2(N_STAT) : 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              load_ctl,
    input logic              shift_ctl,
    input logic              arm_ctl,
    input logic [BUS_W-1:0]  bus_hi,
    input logic [BUS_W-1:0]  bus_lo,
    input logic [N_STAT-1:0] stat_in,
    input logic [SEL_W-1:0]  stat_sel,
    input logic              route_sel,
    input logic              ser_en,
    input logic [2:0]        host_rd,
    input logic [SR_W-1:0]   sr_q,
    input logic              flag_q
);
    assert_load_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $rose(load_ctl)) |=> (sr_q == $past({bus_hi, bus_lo})));

    assert_shift_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $rose(shift_ctl) && !$rose(load_ctl))
        |=> (sr_q == {1'b0, $past(sr_q[SR_W-1:1])}));

    assert_no_edge_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$rose(shift_ctl) && !$rose(load_ctl)) |=> $stable(sr_q));

    assert_serial_gated_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !ser_en |-> (host_rd[2] == 1'b0));

    assert_armed_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (arm_ctl && !stat_in[stat_sel]) |=> flag_q);

    assert_clear_cond_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!arm_ctl && stat_in[stat_sel]) |=> !flag_q);

    assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && !(!arm_ctl && stat_in[stat_sel])) |=> flag_q);

    assert_unrouted_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (route_sel ? host_rd[0] : host_rd[1]) == 1'b0);
endmodule

bind capture_serializer cs_checker #(.BUS_W(BUS_W), .N_STAT(N_STAT)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_ctl (load_ctl),
    .shift_ctl(shift_ctl),
    .arm_ctl  (arm_ctl),
    .bus_hi   (bus_hi),
    .bus_lo   (bus_lo),
    .stat_in  (stat_in),
    .stat_sel (stat_sel),
    .route_sel(route_sel),
    .ser_en   (ser_en),
    .host_rd  (host_rd),
    .sr_q     (sr_q),
    .flag_q   (flag_q)
);

// File: tb/sim_capture_serializer.sv
`timescale 1ns/1ps
module sim_capture_serializer;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        load_ctl, shift_ctl, arm_ctl, route_sel, ser_en;
    logic [15:0] bus_hi, bus_lo;
    logic [3:0]  stat_in;
    logic [1:0]  stat_sel;
    logic [2:0]  host_rd;

    int total = 0;
    int fails = 0;

    always #2.5 clk = ~clk;

    capture_serializer u0 (
        .clk(clk), .rst_n(rst_n), .load_ctl(load_ctl), .shift_ctl(shift_ctl),
        .arm_ctl(arm_ctl), .bus_hi(bus_hi), .bus_lo(bus_lo), .stat_in(stat_in),
        .stat_sel(stat_sel), .route_sel(route_sel), .ser_en(ser_en), .host_rd(host_rd)
    );

    localparam logic [31:0] VECS [4] = '{
        32'h8000_0001, 32'hFFFF_0000, 32'h1234_ABCD, 32'h0000_FFFF
    };

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic pulse_load();
        load_ctl = 1'b1; step();
        load_ctl = 1'b0; step();
    endtask

    task automatic pulse_shift();
        shift_ctl = 1'b1; step();
        shift_ctl = 1'b0; step();
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++;
        fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        rst_n = 1'b0; load_ctl = 0; shift_ctl = 0; arm_ctl = 0; route_sel = 0;
        ser_en = 1'b1; bus_hi = '0; bus_lo = '0; stat_in = 4'hF; stat_sel = 2'd2;
        step(); step(); step();
        rst_n = 1'b1; step();
        // R1: all lines low after reset
        check("R1 reset lines", 32'(host_rd), 32'h0);

        // R2 R3: table walk
        for (int v = 0; v < 4; v++) begin
            bus_hi = VECS[v][31:16];
            bus_lo = VECS[v][15:0];
            pulse_load();
            for (int k = 0; k < 32; k++) begin
                check(k == 0 ? "R2 first bit" : "R3 shifted bit",
                      32'(host_rd[2]), 32'(VECS[v][k]));
                pulse_shift();
            end
            check("R3 zero fill", 32'(host_rd[2]), 32'h0);
        end

        // R4: held-high controls act once
        bus_hi = 16'h0000; bus_lo = 16'h0005;
        load_ctl = 1'b1; step(); step(); step();
        check("R4 load held", 32'(host_rd[2]), 32'h1);
        shift_ctl = 1'b1; step(); step(); step(); step();
        check("R4 shift held", 32'(host_rd[2]), 32'h0);
        shift_ctl = 1'b0; step();
        shift_ctl = 1'b1; step();
        check("R4 second edge", 32'(host_rd[2]), 32'h1);
        // R11: bus change with load held high, no new edge
        bus_lo = 16'hFFFF; step();
        shift_ctl = 1'b0; load_ctl = 1'b0; step();
        pulse_shift();
        check("R11 bus change ignored", 32'(host_rd[2]), 32'h0);

        // R5: simultaneous rise, load wins
        bus_lo = 16'h0002;
        load_ctl = 1'b1; shift_ctl = 1'b1; step();
        check("R5 load priority", 32'(host_rd[2]), 32'h0);
        load_ctl = 1'b0; shift_ctl = 1'b0; step();
        pulse_shift();
        check("R5 next bit", 32'(host_rd[2]), 32'h1);

        // R6: serial enable gating
        ser_en = 1'b0; step();
        check("R6 gated", 32'(host_rd[2]), 32'h0);
        ser_en = 1'b1; step();
        check("R6 ungated", 32'(host_rd[2]), 32'h1);

        // Status latch, select 2, route to line 0
        stat_sel = 2'd2; route_sel = 1'b0; arm_ctl = 1'b1; stat_in = 4'hF; step();
        check("R8 idle no flag", 32'(host_rd[1:0]), 32'h0);
        stat_in = 4'b1101; step();
        check("R7 unselected ignored", 32'(host_rd[1:0]), 32'h0);
        stat_in = 4'b1011; step();
        check("R8 set", 32'(host_rd[1:0]), 32'h1);
        stat_in = 4'hF; step();
        check("R9 hold armed", 32'(host_rd[1:0]), 32'h1);
        arm_ctl = 1'b0; stat_in = 4'b1011; step();
        check("R9 no clear while low", 32'(host_rd[1:0]), 32'h1);
        stat_in = 4'hF; step();
        check("R9 clear", 32'(host_rd[1:0]), 32'h0);
        route_sel = 1'b1; arm_ctl = 1'b1; stat_in = 4'b1011; step();
        check("R10 routed line 1", 32'(host_rd[1:0]), 32'h2);
        route_sel = 1'b0; step();
        check("R10 routed line 0", 32'(host_rd[1:0]), 32'h1);
        stat_sel = 2'd0; arm_ctl = 1'b0; stat_in = 4'b1110; step();
        check("R7 select 0 blocks clear", 32'(host_rd[1:0]), 32'h1);

        // R1: reset mid-operation
        bus_hi = '0; bus_lo = 16'h0001; pulse_load();
        rst_n = 1'b0; step();
        rst_n = 1'b1; step();
        check("R1 reset clears", 32'(host_rd), 32'h0);

        finish_run();
    end
endmodule